// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block sits between a simple host read/write bus and the register file of an ATA task-file device. A 4 KB window of host address space is divided into slots 16 bytes apart. Each slot index selects one device register, and the access size selects whether that slot is a byte register or the data port. Byte accesses reach the seven task-file registers and the device-control / alternate-status register. The alternate-status register can be reached through either of two slot indices. Halfword and word accesses reach the data port only, and their byte order is reversed in both directions.

The device side receives single-cycle strobes during the cycle of the host request, together with the register index and the write data. It returns read data combinationally in that same cycle. The bridge registers the host read data, so the value is presented one clock after the request. Reads from a slot or size that maps to nothing return all-ones of the access width. Writes of that kind raise no strobe. A 32-bit data-port access is sent to the device as one transfer, with a qualifier that marks it as wide.

Top module: `mmio_ata_bridge`

## Requirements
- R1: Only host address bits [11:0] are decoded, and the slot index is bits [11:4]. Bits above bit 11 have no effect on decode or data.
- R2: A byte access (size code 0) to slot 1..7 raises `tf_wr_stb` (write) or `tf_rd_stb` (read) with `tf_sel` equal to the slot number. Write data is `host_wdata[7:0]`. Read data is `tf_rdata` zero-extended.
- R3: A byte write to slot 8 or slot 22 raises `ctl_wr_stb` with `host_wdata[7:0]`. A byte read at either slot raises `alt_rd_stb` and returns `alt_rdata` zero-extended.
- R4: A halfword (size code 1) or word (size code 2) access to slot 0 raises exactly one data-port strobe. `dp_wide` is 0 for a halfword and 1 for a word.
- R5: Data-port write data is byte-reversed. For a halfword, `dp_wdata` = {16'h0, wdata[7:0], wdata[15:8]}. For a word, byte k of `dp_wdata` is byte 3-k of `host_wdata`.
- R6: Data-port read data is byte-reversed in the same way before it is returned, with the upper half zero for a halfword.
- R7: A read that maps to no register returns 0xFF for a byte, 0xFFFF for a halfword, and 0xFFFFFFFF for a word or for the unused size code 3. This includes a byte read at slot 0.
- R8: A write that maps to no register, whether by slot or by size, raises no strobe.
- R9: Strobes are raised only in a cycle with `host_req` high, and at most one is high at a time. `host_rdata` is loaded on the clock edge that ends a read request and holds its value through idle cycles and writes.
- R10: While synchronous reset `rst` is high, all strobes are low. The clock edge at which `rst` is high clears `host_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host access valid for this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 unused |
| host_addr | input | HADDR_W | Host byte address; low WIN_W bits decoded |
| host_wdata | input | 32 | Host write data, right-aligned |
| host_rdata | output | 32 | Registered host read data |
| tf_wr_stb | output | 1 | Task-file register write strobe |
| tf_rd_stb | output | 1 | Task-file register read strobe |
| tf_sel | output | 3 | Task-file register number 1..7 |
| tf_wdata | output | 8 | Task-file write byte |
| tf_rdata | input | 8 | Task-file read byte |
| ctl_wr_stb | output | 1 | Device-control write strobe |
| ctl_wdata | output | 8 | Device-control write byte |
| alt_rd_stb | output | 1 | Alternate-status read strobe |
| alt_rdata | input | 8 | Alternate-status byte |
| dp_wr_stb | output | 1 | Data-port write strobe |
| dp_rd_stb | output | 1 | Data-port read strobe |
| dp_wide | output | 1 | Data-port transfer is 32 bits |
| dp_wdata | output | 32 | Byte-reversed data-port write data |
| dp_rdata | input | 32 | Data-port read data from the device |

## Verification
The bench builds the bridge with its defaults: a 32-bit host address, a 12-bit window and a 16-byte slot stride. With these values, addresses that carry ones above bit 11 can be used to show that they alias the low window. Slot 22 sits inside the window, so the second alternate-status alias can be exercised. The 32-bit data width gives both the halfword and the word byte-reversal paths, so each reversal can be told apart from identity by distinct byte values.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_DATA = 2'd3
  } target_e;

  // All-ones fill for a read that maps to nothing, sized to the access.
  function automatic logic [31:0] miss_fill(input acc_size_e sz);
    case (sz)
      ACC_BYTE: miss_fill = 32'h0000_00FF;
      ACC_HALF: miss_fill = 32'h0000_FFFF;
      default:  miss_fill = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ata_index_decode.sv
module ata_index_decode
  import ata_bridge_pkg::*;
#(
  parameter int WIN_W     = 12,
  parameter int REG_SHIFT = 4,
  parameter int TF_FIRST  = 1,
  parameter int TF_LAST   = 7,
  parameter int CTL_IDX_A = 8,
  parameter int CTL_IDX_B = 22,
  parameter int DATA_IDX  = 0
) (
  input  logic [WIN_W-1:0] win_addr,
  input  acc_size_e        size,
  output target_e          target,
  output logic [2:0]       tf_num
);
  localparam int IDX_W = WIN_W - REG_SHIFT;

  logic [IDX_W-1:0] idx;
  logic [REG_SHIFT-1:0] unused_offs;

  assign idx         = win_addr[WIN_W-1:REG_SHIFT];
  assign unused_offs = win_addr[REG_SHIFT-1:0];
  assign tf_num      = idx[2:0];

  always_comb begin
    target = TGT_NONE;
    case (size)
      ACC_BYTE: begin
        if (idx >= IDX_W'(TF_FIRST) && idx <= IDX_W'(TF_LAST))
          target = TGT_TASK;
        else if (idx == IDX_W'(CTL_IDX_A) || idx == IDX_W'(CTL_IDX_B))
          target = TGT_CTRL;
      end
      ACC_HALF, ACC_WORD: begin
        if (idx == IDX_W'(DATA_IDX))
          target = TGT_DATA;
      end
      default: target = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/ata_lane_swap.sv
module ata_lane_swap
  import ata_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  acc_size_e         size,
  output logic [DATA_W-1:0] dout
);
  localparam int NB    = DATA_W / 8;
  localparam int PAD_H = DATA_W - 16;
  localparam int PAD_B = DATA_W - 8;

  logic [DATA_W-1:0] word_sw;
  logic [15:0]       half_sw;

  for (genvar k = 0; k < NB; k++) begin : g_word
    assign word_sw[8*k +: 8] = din[8*(NB-1-k) +: 8];
  end

  for (genvar k = 0; k < 2; k++) begin : g_half
    assign half_sw[8*k +: 8] = din[8*(1-k) +: 8];
  end

  always_comb begin
    case (size)
      ACC_WORD: dout = word_sw;
      ACC_HALF: dout = {{PAD_H{1'b0}}, half_sw};
      default:  dout = {{PAD_B{1'b0}}, din[7:0]};
    endcase
  end

endmodule

// File: rtl/ata_read_mux.sv
module ata_read_mux
  import ata_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  target_e           target,
  input  acc_size_e         size,
  input  logic [7:0]        tf_byte,
  input  logic [7:0]        alt_byte,
  input  logic [DATA_W-1:0] dp_swapped,
  output logic [DATA_W-1:0] rd_next
);
  localparam int PAD_B = DATA_W - 8;

  always_comb begin
    case (target)
      TGT_TASK: rd_next = {{PAD_B{1'b0}}, tf_byte};
      TGT_CTRL: rd_next = {{PAD_B{1'b0}}, alt_byte};
      TGT_DATA: rd_next = dp_swapped;
      default:  rd_next = DATA_W'(miss_fill(size));
    endcase
  end

endmodule

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge
  import ata_bridge_pkg::*;
#(
  parameter int HADDR_W   = 32,
  parameter int WIN_W     = 12,
  parameter int REG_SHIFT = 4,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [1:0]         host_size,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               tf_wr_stb,
  output logic               tf_rd_stb,
  output logic [2:0]         tf_sel,
  output logic [7:0]         tf_wdata,
  input  logic [7:0]         tf_rdata,
  output logic               ctl_wr_stb,
  output logic [7:0]         ctl_wdata,
  output logic               alt_rd_stb,
  input  logic [7:0]         alt_rdata,
  output logic               dp_wr_stb,
  output logic               dp_rd_stb,
  output logic               dp_wide,
  output logic [DATA_W-1:0]  dp_wdata,
  input  logic [DATA_W-1:0]  dp_rdata
);
  acc_size_e         size;
  target_e           target;
  logic              acc_go;
  logic              acc_rd;
  logic              acc_wr;
  logic              acc_miss;
  logic [DATA_W-1:0] dp_rd_swapped;
  logic [DATA_W-1:0] rd_next;
  logic [HADDR_W-WIN_W-1:0] unused_hi;

  assign size      = acc_size_e'(host_size);
  assign unused_hi = host_addr[HADDR_W-1:WIN_W];

  ata_index_decode #(
    .WIN_W    (WIN_W),
    .REG_SHIFT(REG_SHIFT)
  ) u_dec (
    .win_addr(host_addr[WIN_W-1:0]),
    .size    (size),
    .target  (target),
    .tf_num  (tf_sel)
  );

  // Named access events used by the bound checker.
  assign acc_go   = host_req & ~rst;
  assign acc_rd   = acc_go & ~host_we;
  assign acc_wr   = acc_go & host_we;
  assign acc_miss = (target == TGT_NONE);

  assign tf_wr_stb  = acc_wr & (target == TGT_TASK);
  assign tf_rd_stb  = acc_rd & (target == TGT_TASK);
  assign ctl_wr_stb = acc_wr & (target == TGT_CTRL);
  assign alt_rd_stb = acc_rd & (target == TGT_CTRL);
  assign dp_wr_stb  = acc_wr & (target == TGT_DATA);
  assign dp_rd_stb  = acc_rd & (target == TGT_DATA);
  assign dp_wide    = (size == ACC_WORD);

  assign tf_wdata  = host_wdata[7:0];
  assign ctl_wdata = host_wdata[7:0];

  ata_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .din (host_wdata),
    .size(size),
    .dout(dp_wdata)
  );

  ata_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .din (dp_rdata),
    .size(size),
    .dout(dp_rd_swapped)
  );

  ata_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .target    (target),
    .size      (size),
    .tf_byte   (tf_rdata),
    .alt_byte  (alt_rdata),
    .dp_swapped(dp_rd_swapped),
    .rd_next   (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (acc_rd)
      host_rdata <= rd_next;
  end

endmodule

// File: rtl/mmio_ata_bridge_chk.sv
module mmio_ata_bridge_chk #(
  parameter int HADDR_W   = 32,
  parameter int WIN_W     = 12,
  parameter int REG_SHIFT = 4,
  parameter int DATA_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               host_req,
  input logic               host_we,
  input logic [1:0]         host_size,
  input logic [HADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               tf_wr_stb,
  input logic               tf_rd_stb,
  input logic               ctl_wr_stb,
  input logic               alt_rd_stb,
  input logic               dp_wr_stb,
  input logic               dp_rd_stb,
  input logic               dp_wide,
  input logic [DATA_W-1:0]  dp_rdata,
  input logic               acc_miss
);
  logic [5:0] stb_vec;
  logic       slot0;
  logic [HADDR_W-1:0] unused_addr;

  assign stb_vec     = {tf_wr_stb, tf_rd_stb, ctl_wr_stb, alt_rd_stb, dp_wr_stb, dp_rd_stb};
  assign slot0       = (host_addr[WIN_W-1:REG_SHIFT] == '0);
  assign unused_addr = host_addr;

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_vec));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !host_req |-> (stb_vec == '0));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (stb_vec == '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (host_rdata == '0));

  // R8
  byte_no_dp_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_size == 2'd0) |-> (!dp_wr_stb && !dp_rd_stb));

  // R8
  wide_no_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_size != 2'd0) |-> (!tf_wr_stb && !ctl_wr_stb && !tf_rd_stb && !alt_rd_stb));

  // R4
  dp_width_chk: assert property (@(posedge clk) disable iff (rst)
    (dp_wr_stb || dp_rd_stb) |-> (dp_wide == (host_size == 2'd2)));

  // R7
  miss_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && acc_miss && host_size == 2'd0) |=> (host_rdata == 32'h0000_00FF));

  // R7
  miss_word_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && acc_miss && host_size == 2'd2) |=> (host_rdata == 32'hFFFF_FFFF));

  // R6
  word_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (host_req && !host_we && host_size == 2'd2 && slot0) |=>
      (host_rdata == {$past(dp_rdata[7:0]), $past(dp_rdata[15:8]),
                      $past(dp_rdata[23:16]), $past(dp_rdata[31:24])}));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_req || host_we) |=> $stable(host_rdata));

endmodule

bind mmio_ata_bridge mmio_ata_bridge_chk #(
  .HADDR_W  (HADDR_W),
  .WIN_W    (WIN_W),
  .REG_SHIFT(REG_SHIFT),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/sim_mmio_ata_bridge.sv
module sim_mmio_ata_bridge;

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [2:0]  stb;
    logic [31:0] exp;
  } vec_t;

  // strobe codes: 0 none, 1 tf_wr, 2 tf_rd, 3 ctl_wr, 4 alt_rd, 5 dp_wr, 6 dp_rd
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b1, 2'd0, 32'h0000_0010, 32'h0000_005A, 3'd1, 32'h0000_015A}, // R2
    '{4'd2,  1'b1, 2'd0, 32'h0000_0070, 32'h0000_00EC, 3'd1, 32'h0000_07EC}, // R2
    '{4'd3,  1'b1, 2'd0, 32'h0000_0080, 32'h0000_0006, 3'd3, 32'h0000_0006}, // R3
    '{4'd3,  1'b1, 2'd0, 32'h0000_0160, 32'h0000_0002, 3'd3, 32'h0000_0002}, // R3
    '{4'd5,  1'b1, 2'd1, 32'h0000_0000, 32'h0000_1234, 3'd5, 32'h0000_3412}, // R5
    '{4'd5,  1'b1, 2'd2, 32'h0000_0000, 32'h1122_3344, 3'd5, 32'h4433_2211}, // R5
    '{4'd8,  1'b1, 2'd0, 32'h0000_0000, 32'h0000_0077, 3'd0, 32'h0000_0000}, // R8
    '{4'd8,  1'b1, 2'd1, 32'h0000_0010, 32'h0000_BEEF, 3'd0, 32'h0000_0000}, // R8
    '{4'd8,  1'b1, 2'd0, 32'h0000_0090, 32'h0000_0011, 3'd0, 32'h0000_0000}, // R8
    '{4'd8,  1'b1, 2'd2, 32'h0000_0080, 32'hCAFE_F00D, 3'd0, 32'h0000_0000}, // R8
    '{4'd2,  1'b0, 2'd0, 32'h0000_0030, 32'h0000_0000, 3'd2, 32'h0000_00A3}, // R2
    '{4'd3,  1'b0, 2'd0, 32'h0000_0080, 32'h0000_0000, 3'd4, 32'h0000_005C}, // R3
    '{4'd3,  1'b0, 2'd0, 32'h0000_0160, 32'h0000_0000, 3'd4, 32'h0000_005C}, // R3
    '{4'd6,  1'b0, 2'd1, 32'h0000_0000, 32'h0000_0000, 3'd6, 32'h0000_4433}, // R6
    '{4'd6,  1'b0, 2'd2, 32'h0000_0000, 32'h0000_0000, 3'd6, 32'h4433_2211}, // R6
    '{4'd7,  1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 3'd0, 32'h0000_00FF}, // R7
    '{4'd7,  1'b0, 2'd1, 32'h0000_0020, 32'h0000_0000, 3'd0, 32'h0000_FFFF}, // R7
    '{4'd7,  1'b0, 2'd2, 32'h0000_0160, 32'h0000_0000, 3'd0, 32'hFFFF_FFFF}, // R7
    '{4'd1,  1'b0, 2'd0, 32'hABC0_1050, 32'h0000_0000, 3'd2, 32'h0000_00A5}, // R1
    '{4'd7,  1'b0, 2'd0, 32'h0000_00F0, 32'h0000_0000, 3'd0, 32'h0000_00FF}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_size = 2'd0;
  logic [31:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tf_wr_stb, tf_rd_stb, ctl_wr_stb, alt_rd_stb, dp_wr_stb, dp_rd_stb, dp_wide;
  logic [2:0]  tf_sel;
  logic [7:0]  tf_wdata, ctl_wdata, tf_rdata, alt_rdata;
  logic [31:0] dp_wdata, dp_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  // Device model: each register returns a recognisable value.
  assign tf_rdata  = {5'b10100, tf_sel};
  assign alt_rdata = 8'h5C;
  assign dp_rdata  = 32'h1122_3344;

  mmio_ata_bridge u0 (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .tf_wr_stb(tf_wr_stb), .tf_rd_stb(tf_rd_stb),
    .tf_sel(tf_sel), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
    .ctl_wr_stb(ctl_wr_stb), .ctl_wdata(ctl_wdata), .alt_rd_stb(alt_rd_stb),
    .alt_rdata(alt_rdata), .dp_wr_stb(dp_wr_stb), .dp_rd_stb(dp_rd_stb),
    .dp_wide(dp_wide), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata)
  );

  function automatic logic [2:0] stb_code();
    int n = int'(tf_wr_stb) + int'(tf_rd_stb) + int'(ctl_wr_stb)
          + int'(alt_rd_stb) + int'(dp_wr_stb) + int'(dp_rd_stb);
    if (n > 1)      return 3'd7;
    if (tf_wr_stb)  return 3'd1;
    if (tf_rd_stb)  return 3'd2;
    if (ctl_wr_stb) return 3'd3;
    if (alt_rd_stb) return 3'd4;
    if (dp_wr_stb)  return 3'd5;
    if (dp_rd_stb)  return 3'd6;
    return 3'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sz,
                       input logic [31:0] addr, input logic [31:0] wd);
    host_req   = 1'b1;
    host_we    = we;
    host_size  = sz;
    host_addr  = addr;
    host_wdata = wd;
  endtask

  initial begin
    logic [2:0]  code;
    logic [31:0] wobs;
    string       tag;

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 rdata after reset", host_rdata, 32'h0);
    check("R10 strobes in reset", {29'h0, stb_code()}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].we, VEC[i].sz, VEC[i].addr, VEC[i].wd);
      #2;
      code = stb_code();
      case (code)
        3'd1:    wobs = {21'h0, tf_sel, tf_wdata};
        3'd3:    wobs = {24'h0, ctl_wdata};
        3'd5:    wobs = dp_wdata;
        default: wobs = 32'h0;
      endcase
      @(negedge clk);
      host_req = 1'b0;
      tag = $sformatf("R%0d vec%0d strobe", VEC[i].req, i);
      check(tag, {29'h0, code}, {29'h0, VEC[i].stb});
      if (VEC[i].we) begin
        tag = $sformatf("R%0d vec%0d wdata", VEC[i].req, i);
        if (VEC[i].stb != 3'd0) check(tag, wobs, VEC[i].exp);
      end else begin
        tag = $sformatf("R%0d vec%0d rdata", VEC[i].req, i);
        check(tag, host_rdata, VEC[i].exp);
      end
    end

    // R4: width qualifier on halfword and word transfers
    @(negedge clk);
    drive(1'b1, 2'd1, 32'h0, 32'h0000_ABCD);
    #2 check("R4 dp_wide half", {31'h0, dp_wide}, 32'h0);
    @(negedge clk);
    drive(1'b1, 2'd2, 32'h0, 32'h0102_0304);
    #2 check("R4 dp_wide word", {31'h0, dp_wide}, 32'h1);
    check("R4 single dp strobe", {29'h0, stb_code()}, 32'h5);
    @(negedge clk);
    host_req = 1'b0;

    // R7: unused size code reads as full all-ones at slot 0
    @(negedge clk);
    drive(1'b0, 2'd3, 32'h0, 32'h0);
    #2 check("R7 size3 no strobe", {29'h0, stb_code()}, 32'h0);
    @(negedge clk);
    host_req = 1'b0;
    check("R7 size3 rdata", host_rdata, 32'hFFFF_FFFF);

    // R9: read data holds across idle and a write
    @(negedge clk);
    drive(1'b0, 2'd0, 32'h0000_0040, 32'h0);
    @(negedge clk);
    host_req = 1'b0;
    check("R9 load rdata", host_rdata, 32'h0000_00A4);
    @(negedge clk);
    check("R9 idle strobe", {29'h0, stb_code()}, 32'h0);
    check("R9 hold idle", host_rdata, 32'h0000_00A4);
    drive(1'b1, 2'd2, 32'h0, 32'hFFFF_0000);
    @(negedge clk);
    host_req = 1'b0;
    check("R9 hold on write", host_rdata, 32'h0000_00A4);

    // R10: reset with a request pending
    @(negedge clk);
    rst = 1'b1;
    drive(1'b0, 2'd2, 32'h0, 32'h0);
    #2 check("R10 strobes gated", {29'h0, stb_code()}, 32'h0);
    @(negedge clk);
    host_req = 1'b0;
    check("R10 rdata cleared", host_rdata, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule